// File: doc/BRIEF.md
# Ping-Pong LIFO Sample Order Reverser

This block sits in the feedback path between a forward sample chain and a reverse sample chain. It sends each forward sample to the reverse chain either in the order it arrived or reversed block by block. When reversal is on, two LIFO stacks take turns. One stack collects the incoming samples while the other is popped onto the reverse chain. A falling edge on the block strobe makes the two stacks change roles. The spacing of those edges therefore sets the block length, and block order is reversed without a gap.

When reversal is off, every sample goes through one delay register unchanged. An input steering stage picks the stack or the bypass path, and an output multiplexer picks the source that loads the output register. A hold input freezes the whole block: no sample is taken, none is produced, and all state keeps its value.

Top module: `order_reverser`

## Requirements
- R1: While `rst_n` is low at a clock edge, `smp_out` becomes 0, both stacks become empty, stack A takes the write role and the remembered strobe value becomes 0.
- R2: With `keep_order`=1 and `hold`=0, `smp_out` after a clock edge equals `smp_in` at that edge, which is a latency of one clock.
- R3: A swap happens only on an advancing edge where `blk_strb` is 0 and its value at the previous advancing edge was 1. A strobe held low for many cycles causes no further swaps.
- R4: With `keep_order`=0, the samples written between two swaps come out newest first. They start with the sample written just before the closing swap, which appears after the swap edge, and one sample follows per advancing clock.
- R5: An advancing edge in reversal mode whose read stack is empty drives `smp_out` to 0.
- R6: While `hold`=1, `smp_out` and all internal state keep their values. `smp_in` is not taken. A strobe pulse that begins and ends entirely within the hold is not seen as an edge.
- R7: Each stack holds `DEPTH` entries (16 by default). Writes after the 16th in one block are dropped, and the first 16 samples of the block are returned newest first.
- R8: At a swap, any unread entries in the old read stack are discarded. The sample on `smp_in` at the swap edge is the first entry of the new write stack.
- R9: With `keep_order`=1, the stacks are neither written nor read, and strobe falling edges cause no swap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| smp_in | input | SMP_W (10) | Sample from the forward chain |
| hold | input | 1 | 1 freezes all data movement and state |
| blk_strb | input | 1 | Block strobe; a falling edge swaps the stack roles |
| keep_order | input | 1 | 0 selects block order reversal, 1 selects the one-register bypass |
| smp_out | output | SMP_W (10) | Sample to the reverse chain, registered |

## Verification
A wrong role select or a wrong stack pointer shows at `smp_out` on the first advancing edge after the next swap. The block then comes out in the wrong order, out of another block, or as a zero where a sample was expected. A lost or extra swap shows within one block length, because the output starts to repeat or drops to zero in the middle of a block. The tests compare every output sample with the values expected across swaps, overflow, held-low strobes, holds and mode changes. Any such fault therefore shows as a miscompare within a few cycles of its cause.

// File: rtl/ordrev_pkg.sv
// Package ordrev_pkg
// Shared defaults and the stack identifier type for the order reverser.
// Assumes: exactly two stacks, which take turns in the write and read roles.
package ordrev_pkg;
    localparam int SMP_W_DEF  = 10;
    localparam int DEPTH_DEF  = 16;
    localparam int NUM_STACKS = 2;

    typedef enum logic {
        STK_A = 1'b0,
        STK_B = 1'b1
    } stk_id_e;
endpackage

// File: rtl/ordrev_fall_det.sv
// Module ordrev_fall_det
// Finds a high-to-low transition of the block strobe. The strobe is compared
// with its value at the previous advancing clock, so a pulse that happens
// entirely during a hold is never seen.
// Assumes: blk_strb is synchronous to clk.
module ordrev_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic adv,
    input  logic strb,
    output logic fall
);
    logic prev_q;

    // Remember the strobe value from the last advancing edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= 1'b0;
        else if (adv)
            prev_q <= strb;
    end

    // An edge counts only on an advancing cycle.
    always_comb fall = adv && prev_q && !strb;

    // R3: after a detected edge the strobe is low, so the next cycle holds no edge.
    a_r3_single_fall: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall);
endmodule

// File: rtl/ordrev_lifo.sv
// Module ordrev_lifo
// One LIFO stack. Its top entry is always visible and reads as zero when the
// stack is empty. A clear empties the stack and may load one new sample as
// its first entry in the same cycle.
// Assumes: push and pop are never asserted together (the caller gives each
// stack a single role per cycle).
module ordrev_lifo #(
    parameter int W     = 10,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic         pop,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic         empty,
    output logic         full
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

    logic [W-1:0]     mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] top_pos;
    logic [CNT_W-1:0] wr_pos;

    // Status flags and the read address of the newest entry.
    always_comb begin
        empty   = (cnt_q == '0);
        full    = (cnt_q == CNT_MAX);
        top_pos = cnt_q - CNT_W'(1);
        wr_pos  = clr ? '0 : cnt_q;
    end

    // The top entry is shown, or zero when nothing is stored.
    always_comb top = empty ? '0 : mem[top_pos[IDX_W-1:0]];

    // Store the pushed sample; a push onto a full stack is dropped.
    always_ff @(posedge clk) begin
        if (push && (clr || !full))
            mem[wr_pos[IDX_W-1:0]] <= din;
    end

    // Track the fill level through clear, push and pop.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (clr)
            cnt_q <= push ? CNT_W'(1) : '0;
        else if (push && !full)
            cnt_q <= cnt_q + CNT_W'(1);
        else if (pop && !empty)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    // R7: the fill level never goes past the stack depth.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX);

    // R7: a push onto a full stack leaves the level at the depth.
    a_r7_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !clr) |=> full);

    // One role per stack per cycle.
    a_r4_single_role: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && pop));
endmodule

// File: rtl/ordrev_ctrl.sv
// Module ordrev_ctrl
// Holds which stack has the write role and works out the roles for the
// current cycle. On a swap cycle the roles are already exchanged, so the
// stack that was just filled is read at once and the other stack is cleared
// and loaded.
// Assumes: fall is asserted only on advancing cycles.
module ordrev_ctrl (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rev_en,
    input  logic                fall,
    output logic                swap,
    output ordrev_pkg::stk_id_e wr_sel,
    output ordrev_pkg::stk_id_e rd_sel
);
    import ordrev_pkg::*;

    stk_id_e wsel_q;

    // A swap needs reversal mode and a detected strobe fall.
    always_comb swap = rev_en && fall;

    // Roles for this cycle, exchanged at once on a swap.
    always_comb begin
        wr_sel = swap ? stk_id_e'(~wsel_q) : wsel_q;
        rd_sel = stk_id_e'(~wr_sel);
    end

    // Keep the write-role owner across cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wsel_q <= STK_A;
        else
            wsel_q <= wr_sel;
    end

    // R9: with reversal off the write-role owner does not change.
    a_r9_no_swap_bypass: assert property (@(posedge clk) disable iff (!rst_n)
        !rev_en |=> (wsel_q == $past(wsel_q)));
endmodule

// File: rtl/order_reverser.sv
// Module order_reverser
// Feedback unit between the forward and reverse sample chains. In reversal
// mode the samples go to the stack with the write role while the other stack
// is popped onto the output. A strobe falling edge exchanges the roles. In
// bypass mode the samples go through the output register unchanged.
// Assumes: all inputs are synchronous to clk.
module order_reverser #(
    parameter int SMP_W = ordrev_pkg::SMP_W_DEF,
    parameter int DEPTH = ordrev_pkg::DEPTH_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp_in,
    input  logic             hold,
    input  logic             blk_strb,
    input  logic             keep_order,
    output logic [SMP_W-1:0] smp_out
);
    import ordrev_pkg::*;

    logic             adv;
    logic             rev_en;
    logic             fall;
    logic             swap;
    stk_id_e          wr_sel;
    stk_id_e          rd_sel;
    logic [SMP_W-1:0] stk_top   [NUM_STACKS];
    logic             stk_empty [NUM_STACKS];
    logic             stk_full  [NUM_STACKS];
    logic [SMP_W-1:0] rd_top;
    logic             rd_empty;
    logic [SMP_W-1:0] out_q;

    // Data moves only when not held; the reversal control is active low.
    always_comb begin
        adv    = !hold;
        rev_en = !keep_order;
    end

    ordrev_fall_det u_fall (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (adv),
        .strb  (blk_strb),
        .fall  (fall)
    );

    ordrev_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .rev_en (rev_en),
        .fall   (fall),
        .swap   (swap),
        .wr_sel (wr_sel),
        .rd_sel (rd_sel)
    );

    // The input steering gives each stack its push, pop and clear.
    for (genvar g = 0; g < NUM_STACKS; g++) begin : g_stk
        localparam stk_id_e ID = stk_id_e'(g);
        logic s_push;
        logic s_pop;
        logic s_clr;

        // Steer this stack according to its role in this cycle.
        always_comb begin
            s_push = adv && rev_en && (wr_sel == ID);
            s_pop  = adv && rev_en && (rd_sel == ID);
            s_clr  = swap && (wr_sel == ID);
        end

        ordrev_lifo #(
            .W     (SMP_W),
            .DEPTH (DEPTH)
        ) u_lifo (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (s_clr),
            .push  (s_push),
            .pop   (s_pop),
            .din   (smp_in),
            .top   (stk_top[g]),
            .empty (stk_empty[g]),
            .full  (stk_full[g])
        );
    end

    // Output mux: the top of the read stack in reversal mode.
    always_comb begin
        rd_top   = stk_top[rd_sel];
        rd_empty = stk_empty[rd_sel];
    end

    // Output register, which is also the one-stage bypass delay.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_q <= '0;
        else if (adv)
            out_q <= keep_order ? smp_in : rd_top;
    end

    assign smp_out = out_q;

    // R2: bypass gives the input back one clock later.
    a_r2_bypass_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_order && !hold) |=> (smp_out == $past(smp_in)));

    // R6: a held cycle leaves the output unchanged.
    a_r6_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> $stable(smp_out));

    // R5: reading an empty stack gives zero.
    a_r5_empty_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !keep_order && rd_empty) |=> (smp_out == '0));

    // R3: a swap never happens on a held cycle.
    a_r3_swap_advances: assert property (@(posedge clk) disable iff (!rst_n)
        swap |-> !hold);
endmodule

// File: tb/order_reverser_tb.sv
module order_reverser_tb;
    localparam int W = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] smp_in = '0;
    logic         hold = 1'b0;
    logic         blk_strb = 1'b1;
    logic         keep_order = 1'b0;
    logic [W-1:0] smp_out;

    int n_vec = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    order_reverser u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .smp_in     (smp_in),
        .hold       (hold),
        .blk_strb   (blk_strb),
        .keep_order (keep_order),
        .smp_out    (smp_out)
    );

    task automatic check(input string req, input logic [W-1:0] exp);
        n_vec++;
        if (smp_out !== exp) begin
            n_bad++;
            $display("FAIL %s: smp_out=%0d expected=%0d at %0t", req, smp_out, exp, $time);
        end
    endtask

    // One advancing clock with the given sample and strobe.
    task automatic tick(input logic [W-1:0] d, input logic s);
        smp_in = d; blk_strb = s; hold = 1'b0;
        @(posedge clk); #1;
    endtask

    // One held clock.
    task automatic hold_tick(input logic [W-1:0] d, input logic s);
        smp_in = d; blk_strb = s; hold = 1'b1;
        @(posedge clk); #1;
        hold = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; hold = 1'b0; blk_strb = 1'b1; keep_order = 1'b0; smp_in = 10'd999;
        @(posedge clk); #1;
        @(posedge clk); #1;
        check("R1 reset output", '0);
        rst_n = 1'b1;
    endtask

    // R1, R5: after reset the read stack is empty, so the output stays zero.
    task automatic t_reset_empty();
        do_reset();
        for (int i = 0; i < 3; i++) begin
            tick(W'(30 + i), 1'b1);
            check("R5 empty read after reset", '0);
        end
    endtask

    // R4: continuous block reversal over several blocks.
    task automatic t_reverse();
        do_reset();
        tick(0, 1'b1);
        for (int i = 0; i < 8; i++) tick(W'(10 + i), (i == 0) ? 1'b0 : 1'b1);
        for (int i = 0; i < 8; i++) begin
            tick(W'(50 + i), (i == 0) ? 1'b0 : 1'b1);
            check("R4 block 1 reversed", W'(17 - i));
        end
        for (int i = 0; i < 8; i++) begin
            tick(W'(0), (i == 0) ? 1'b0 : 1'b1);
            check("R4 block 2 reversed", W'(57 - i));
        end
    endtask

    // R3, R5: a strobe held low gives one swap only; the stack then reads empty.
    task automatic t_held_low();
        do_reset();
        tick(0, 1'b1);
        for (int i = 0; i < 8; i++) tick(W'(10 + i), (i == 0) ? 1'b0 : 1'b1);
        for (int i = 0; i < 10; i++) begin
            tick(W'(90 + i), 1'b0);
            check("R3 held-low strobe no re-swap", (i < 8) ? W'(17 - i) : W'(0));
        end
    endtask

    // R7: a block longer than the depth keeps its first 16 samples.
    task automatic t_overflow();
        do_reset();
        tick(0, 1'b1);
        for (int i = 0; i < 20; i++) tick(W'(100 + i), (i == 0) ? 1'b0 : 1'b1);
        for (int i = 0; i < 17; i++) begin
            tick(0, (i == 0) ? 1'b0 : 1'b1);
            check("R7 overflow dropped", (i < 16) ? W'(115 - i) : W'(0));
        end
    endtask

    // R8: a swap before the read stack is drained discards the rest.
    task automatic t_discard();
        do_reset();
        tick(0, 1'b1);
        for (int i = 0; i < 8; i++) tick(W'(200 + i), (i == 0) ? 1'b0 : 1'b1);
        tick(300, 1'b0); check("R8 read block start", 207);
        tick(301, 1'b1); check("R8 read second", 206);
        tick(400, 1'b0); check("R8 early swap newest", 301);
        tick(401, 1'b1); check("R8 early swap oldest", 300);
        tick(402, 1'b1); check("R8 old entries discarded", 0);
    endtask

    // R6: hold freezes output and state, drops samples, hides inner strobe pulses.
    task automatic t_hold();
        do_reset();
        tick(0, 1'b1);
        for (int i = 0; i < 8; i++) tick(W'(10 + i), (i == 0) ? 1'b0 : 1'b1);
        tick(50, 1'b0); check("R6 before hold", 17);
        tick(51, 1'b1); check("R6 before hold", 16);
        hold_tick(700, 1'b0); check("R6 hold keeps output", 16);
        hold_tick(701, 1'b1); check("R6 hold keeps output", 16);
        hold_tick(702, 1'b0); check("R6 hold keeps output", 16);
        hold_tick(703, 1'b1); check("R6 hold keeps output", 16);
        for (int i = 0; i < 6; i++) begin
            tick(W'(52 + i), 1'b1);
            check("R6 resume after hold", W'(15 - i));
        end
        for (int i = 0; i < 9; i++) begin
            tick(W'(60 + i), (i == 0) ? 1'b0 : 1'b1);
            check("R6 held samples not stored", (i < 8) ? W'(57 - i) : W'(0));
        end
    endtask

    // R2, R9: bypass passes samples, leaves the stacks alone, ignores strobe falls.
    task automatic t_bypass();
        do_reset();
        for (int i = 0; i < 4; i++) tick(W'(70 + i), 1'b1);
        keep_order = 1'b1;
        for (int i = 0; i < 4; i++) begin
            tick(W'(5 + i), i[0]);
            check("R2 bypass one-clock delay", W'(5 + i));
        end
        keep_order = 1'b0;
        tick(80, 1'b1); check("R9 no swap in bypass", 0);
        tick(81, 1'b0); check("R9 stacks untouched newest", 80);
        for (int i = 0; i < 4; i++) begin
            tick(0, 1'b1);
            check("R9 stacks untouched", W'(73 - i));
        end
        tick(0, 1'b1); check("R9 bypass samples not stored", 0);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #2;
        t_reset_empty();
        t_reverse();
        t_held_low();
        t_overflow();
        t_discard();
        t_hold();
        t_bypass();
        do_reset();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule